// File: doc/BRIEF.md
# Page Write Collector and Program Sequencer

This block sits behind the serial front end of a byte-wide nonvolatile memory. While an array-write command is in progress it receives a start address and then a stream of data bytes, and places each byte in a one-page holding buffer. A per-slot valid mask records which slots hold a byte. Only the low page-offset bits of the address advance from byte to byte, so a long burst wraps inside the page and the later bytes replace the earlier ones.

When chip select is released, the block decides whether to commit the page. It commits only if the release falls exactly on a byte boundary, write permission is granted and at least one byte was received. A committed page is flushed to the array one slot per cycle in ascending offset order, and only the slots that were loaded are written. A self-timed programming interval of a parameterised length follows. The block reports busy from the commit to the end of that interval, and then pulses a request that clears the write-enable latch. While busy, every frame event and every strobe is ignored.

Top module: `page_prog_seq`

## Requirements
- R1: After reset, busy, arr_we and wel_clr are all 0.
- R2: The array address of a byte keeps the upper bits of the loaded start address. Its low PAGE_BITS bits are the start offset plus the number of bytes that came before it in the frame, taken modulo the page size (64 by default).
- R3: When more than one page of bytes is sent, every page slot is written exactly once, with the last byte loaded into that slot.
- R4: A chip-select rise with cs_bit_pos not equal to 0 (0 means byte boundary) drops the write: busy stays 0 and nothing is written.
- R5: A chip-select rise while wr_allow is 0 drops the write.
- R6: A chip-select rise with no byte loaded since the last chip-select fall drops the write.
- R7: After a commit, the flush writes each loaded slot once, one per cycle, in ascending offset order, with the data loaded for that slot. Slot offset k is presented in the (k+1)th cycle after the commit edge.
- R8: busy rises in the cycle after an accepted chip-select rise and stays high for exactly PAGE_SZ + PROG_CYCLES cycles.
- R9: wel_clr pulses high for one cycle, in the first cycle after busy falls, and never after a dropped write.
- R10: While busy, byte and address strobes and chip-select events have no effect: the interval is not restarted and no byte is carried into a later commit.
- R11: A chip-select fall discards all bytes loaded before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_fall | input | 1 | One-cycle pulse: frame start (chip select went low) |
| cs_rise | input | 1 | One-cycle pulse: frame end (chip select went high) |
| cs_bit_pos | input | BIT_W | Bits of the current byte received when cs_rise pulses; 0 means byte boundary |
| addr_load | input | 1 | Strobe: load the start address of the write |
| addr_in | input | ADDR_W | Start address |
| byte_load | input | 1 | Strobe: one complete data byte |
| byte_in | input | DATA_W | Data byte |
| wr_allow | input | 1 | Write permission from the protection logic, sampled at cs_rise |
| busy | output | 1 | High from commit to the end of programming |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
A wrong pointer or a wrong valid mask does not show up at once. It appears only after the next commit: as a missing, extra or misplaced write during the flush, within PAGE_SZ cycles of the chip-select rise. A wrong phase or a wrong timer count shows up as a busy edge in the wrong cycle or a misplaced wel_clr pulse, at most PAGE_SZ + PROG_CYCLES cycles after the commit. The bench compares every output on every cycle against a behavioural model. It also checks each frame's list of array writes against offsets computed from the requirements.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        PH_COLLECT = 2'd0,
        PH_FLUSH   = 2'd1,
        PH_PROGRAM = 2'd2
    } phase_e;
endpackage

// File: rtl/pwb_store.sv
module pwb_store #(
    parameter int PAGE_BITS = 6,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld,
    input  logic [PAGE_BITS-1:0] ld_idx,
    input  logic [DATA_W-1:0]    ld_data,
    input  logic                 clr,
    input  logic [PAGE_BITS-1:0] rd_idx,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic                 any_valid
);
    localparam int PAGE_SZ = 1 << PAGE_BITS;

    typedef struct packed {
        logic [PAGE_SZ-1:0][DATA_W-1:0] mem;
        logic [PAGE_SZ-1:0]             mask;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.mask = '0;
        end else if (ld) begin
            st_d.mem[ld_idx]  = ld_data;
            st_d.mask[ld_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.mem[rd_idx];
    assign rd_valid  = st_q.mask[rd_idx];
    assign any_valid = |st_q.mask;

    // R11: a clear leaves no loaded slot behind
    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_valid);
    // R3: one load marks at most one new slot
    a_r3_one_slot_per_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> ($countones(st_q.mask) <= $countones($past(st_q.mask)) + 1));
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
    parameter int PROG_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic done
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PROG_CYCLES - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = LOAD_VAL;
        end else if (t_q.run) begin
            if (t_q.cnt == '0) t_d.run = 1'b0;
            else               t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign running = t_q.run;
    assign done    = t_q.run && (t_q.cnt == '0);

    // R8: count stays inside the interval
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (int'(t_q.cnt) < PROG_CYCLES));
    // R8: interval ends right after its last cycle
    a_r8_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !running);
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
    parameter int ADDR_W      = 15,
    parameter int PAGE_BITS   = 6,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 1000000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_fall,
    input  logic                       cs_rise,
    input  logic [$clog2(DATA_W)-1:0]  cs_bit_pos,
    input  logic                       addr_load,
    input  logic [ADDR_W-1:0]          addr_in,
    input  logic                       byte_load,
    input  logic [DATA_W-1:0]          byte_in,
    input  logic                       wr_allow,
    output logic                       busy,
    output logic                       arr_we,
    output logic [ADDR_W-1:0]          arr_addr,
    output logic [DATA_W-1:0]          arr_wdata,
    output logic                       wel_clr
);
    import pwb_pkg::*;

    localparam int UP_W = ADDR_W - PAGE_BITS;
    localparam logic [PAGE_BITS-1:0] LAST_SLOT = '1;

    typedef struct packed {
        phase_e               phase;
        logic [UP_W-1:0]      upper;
        logic [PAGE_BITS-1:0] ptr;
        logic [PAGE_BITS-1:0] scan;
        logic                 wel;
    } seq_t;

    seq_t s_d, s_q;

    logic              st_ld, st_clr, tmr_start, tmr_run, tmr_done;
    logic              rd_valid, any_valid;
    logic [DATA_W-1:0] rd_data;

    always_comb begin
        s_d       = s_q;
        s_d.wel   = 1'b0;
        st_ld     = 1'b0;
        st_clr    = 1'b0;
        tmr_start = 1'b0;
        case (s_q.phase)
            PH_COLLECT: begin
                if (cs_fall) st_clr = 1'b1;
                if (addr_load) {s_d.upper, s_d.ptr} = addr_in;
                if (byte_load) begin
                    st_ld   = 1'b1;
                    s_d.ptr = s_q.ptr + 1'b1;
                end
                if (cs_rise) begin
                    if (cs_bit_pos == '0 && wr_allow && any_valid) begin
                        s_d.phase = PH_FLUSH;
                        s_d.scan  = '0;
                    end else begin
                        st_clr = 1'b1;
                    end
                end
            end
            PH_FLUSH: begin
                s_d.scan = s_q.scan + 1'b1;
                if (s_q.scan == LAST_SLOT) begin
                    s_d.phase = PH_PROGRAM;
                    tmr_start = 1'b1;
                    st_clr    = 1'b1;
                end
            end
            PH_PROGRAM: begin
                if (tmr_done) begin
                    s_d.phase = PH_COLLECT;
                    s_d.wel   = 1'b1;
                end
            end
            default: s_d.phase = PH_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_COLLECT, default: '0};
        else        s_q <= s_d;
    end

    pwb_store #(.PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ld(st_ld), .ld_idx(s_q.ptr), .ld_data(byte_in),
        .clr(st_clr), .rd_idx(s_q.scan),
        .rd_data(rd_data), .rd_valid(rd_valid), .any_valid(any_valid)
    );

    pwb_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start),
        .running(tmr_run), .done(tmr_done)
    );

    assign busy      = (s_q.phase != PH_COLLECT);
    assign arr_we    = (s_q.phase == PH_FLUSH) && rd_valid;
    assign arr_addr  = {s_q.upper, s_q.scan};
    assign arr_wdata = rd_data;
    assign wel_clr   = s_q.wel;

    // R8: busy starts only from an accepted frame end
    a_r8_commit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_rise) && $past(cs_bit_pos) == '0 && $past(wr_allow)));
    // R9: latch clear follows the end of busy
    a_r9_wel_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> (!busy && $past(busy)));
    a_r9_wel_single: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wel_clr);
    // R2: page bits stay fixed across a flush
    a_r2_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> (arr_addr[ADDR_W-1:PAGE_BITS] == $past(arr_addr[ADDR_W-1:PAGE_BITS])));
    // R7: flush order is ascending
    a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> (arr_addr[PAGE_BITS-1:0] > $past(arr_addr[PAGE_BITS-1:0])));
    // R8: the timer runs only in the programming phase
    a_r8_timer_phase: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_run |-> busy);
endmodule

// File: tb/sim_page_prog_seq.sv
module sim_page_prog_seq;
    localparam int P  = 20;
    localparam int PG = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_fall = 0, cs_rise = 0, addr_load = 0, byte_load = 0, wr_allow = 0;
    logic [2:0]  cs_bit_pos = 0;
    logic [14:0] addr_in = 0;
    logic [7:0]  byte_in = 0;
    logic busy, arr_we, wel_clr;
    logic [14:0] arr_addr;
    logic [7:0]  arr_wdata;

    always #2.5 clk = ~clk;

    page_prog_seq #(.ADDR_W(15), .PAGE_BITS(6), .DATA_W(8), .PROG_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .cs_bit_pos(cs_bit_pos), .addr_load(addr_load), .addr_in(addr_in),
        .byte_load(byte_load), .byte_in(byte_in), .wr_allow(wr_allow),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .wel_clr(wel_clr)
    );

    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    bit   m_act = 0, m_wel = 0, m_any;
    int   m_t = 0, m_up = 0, m_ptr = 0, s_up = 0;
    logic [7:0] m_mem [PG];
    bit         m_vld [PG];
    logic [7:0] s_mem [PG];
    bit         s_vld [PG];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_wel = 0; m_t = 0;
            for (int i = 0; i < PG; i++) m_vld[i] = 0;
        end else if (m_act) begin
            m_t++; m_wel = 0;
            if (m_t == PG + P) begin m_act = 0; m_wel = 1; end
        end else begin
            m_wel = 0;
            if (cs_fall) for (int i = 0; i < PG; i++) m_vld[i] = 0;
            if (addr_load) begin m_up = int'(addr_in) / PG; m_ptr = int'(addr_in) % PG; end
            if (byte_load) begin
                m_mem[m_ptr] = byte_in; m_vld[m_ptr] = 1; m_ptr = (m_ptr + 1) % PG;
            end
            if (cs_rise) begin
                m_any = 0;
                for (int i = 0; i < PG; i++) if (m_vld[i]) m_any = 1;
                if (cs_bit_pos == 0 && wr_allow && m_any) begin
                    m_act = 1; m_t = 0; s_mem = m_mem; s_vld = m_vld; s_up = m_up;
                end
                for (int i = 0; i < PG; i++) m_vld[i] = 0;
            end
        end
    end

    // per-cycle comparison and write log
    int log_addr [$];
    int log_data [$];
    int busy_cycles = 0, wel_pulses = 0;
    bit e_we;

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            e_we = m_act && (m_t < PG) && s_vld[m_t % PG];
            chk("R8 busy per cycle", int'(busy), int'(m_act));
            chk("R9 wel_clr per cycle", int'(wel_clr), int'(m_wel));
            chk("R7 arr_we per cycle", int'(arr_we), int'(e_we));
            if (e_we) begin
                chk("R2 arr_addr per cycle", int'(arr_addr), s_up * PG + m_t);
                chk("R7 arr_wdata per cycle", int'(arr_wdata), int'(s_mem[m_t]));
            end
            if (arr_we) begin log_addr.push_back(int'(arr_addr)); log_data.push_back(int'(arr_wdata)); end
            if (busy) busy_cycles++;
            if (wel_clr) wel_pulses++;
        end
    end

    task automatic clear_log();
        log_addr.delete(); log_data.delete(); busy_cycles = 0; wel_pulses = 0;
    endtask

    task automatic pulse_fall();
        @(negedge clk) cs_fall = 1; @(negedge clk) cs_fall = 0;
    endtask

    task automatic pulse_rise(input int pos, input bit allow);
        @(negedge clk) begin cs_rise = 1; cs_bit_pos = 3'(pos); wr_allow = allow; end
        @(negedge clk) begin cs_rise = 0; cs_bit_pos = 0; end
    endtask

    task automatic send_addr(input int a);
        @(negedge clk) begin addr_load = 1; addr_in = 15'(a); end
        @(negedge clk) addr_load = 0;
    endtask

    task automatic send_bytes(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) begin byte_load = 1; byte_in = 8'(base + i); end
        end
        @(negedge clk) byte_load = 0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 1000) begin @(negedge clk); guard++; end
        repeat (3) @(negedge clk);
    endtask

    // expected writes from the requirements: byte i lands at offset (start+i) mod PG, last one wins
    task automatic expect_page(input string req, input int start, input int n, input int base);
        int   e_d [PG];
        bit   e_v [PG];
        int   k = 0;
        for (int i = 0; i < PG; i++) e_v[i] = 0;
        for (int i = 0; i < n; i++) begin
            e_v[(start % PG + i) % PG] = 1; e_d[(start % PG + i) % PG] = (base + i) & 8'hFF;
        end
        for (int i = 0; i < PG; i++) if (e_v[i]) k++;
        chk({req, " write count"}, log_addr.size(), k);
        k = 0;
        for (int i = 0; i < PG; i++) if (e_v[i] && k < log_addr.size()) begin
            chk({req, " write address"}, log_addr[k], (start / PG) * PG + i);
            chk({req, " write data"}, log_data[k], e_d[i]);
            k++;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 arr_we after reset", int'(arr_we), 0);
        chk("R1 wel_clr after reset", int'(wel_clr), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2 / R7 / R8 / R9: wrap within page
        clear_log();
        pulse_fall(); send_addr('h123E); send_bytes(4, 'hA0); pulse_rise(0, 1); wait_idle();
        expect_page("R2", 'h123E, 4, 'hA0);
        chk("R8 busy length", busy_cycles, PG + P);
        chk("R9 wel pulse count", wel_pulses, 1);

        // R3: overrun of the page
        clear_log();
        pulse_fall(); send_addr('h0045); send_bytes(70, 'h10); pulse_rise(0, 1); wait_idle();
        expect_page("R3", 'h0045, 70, 'h10);

        // R4: misaligned frame end
        clear_log();
        pulse_fall(); send_addr('h0200); send_bytes(3, 'h55); pulse_rise(3, 1);
        repeat (5) @(negedge clk);
        chk("R4 no writes", log_addr.size(), 0);
        chk("R4 no busy", busy_cycles, 0);
        chk("R9 no wel on drop (R4)", wel_pulses, 0);

        // R5: permission denied
        clear_log();
        pulse_fall(); send_addr('h0300); send_bytes(2, 'h66); pulse_rise(0, 0);
        repeat (5) @(negedge clk);
        chk("R5 no writes", log_addr.size(), 0);
        chk("R5 no busy", busy_cycles, 0);

        // R6: zero bytes
        clear_log();
        pulse_fall(); send_addr('h0400); pulse_rise(0, 1);
        repeat (5) @(negedge clk);
        chk("R6 no busy", busy_cycles, 0);
        chk("R9 no wel on drop (R6)", wel_pulses, 0);

        // R11: fall discards earlier bytes
        clear_log();
        pulse_fall(); send_addr('h0500); send_bytes(3, 'h30);
        pulse_fall(); send_addr('h0510); send_bytes(2, 'h40); pulse_rise(0, 1); wait_idle();
        expect_page("R11", 'h0510, 2, 'h40);

        // R10: events during busy are ignored
        clear_log();
        pulse_fall(); send_addr('h0600); send_bytes(2, 'h70); pulse_rise(0, 1);
        send_addr('h0700); send_bytes(3, 'h80); pulse_rise(0, 1); pulse_fall();
        wait_idle();
        expect_page("R10", 'h0600, 2, 'h70);
        chk("R10 interval not restarted", busy_cycles, PG + P);
        clear_log();
        pulse_rise(0, 1);
        repeat (5) @(negedge clk);
        chk("R10 no byte carried over", busy_cycles, 0);

        done_flag = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule